// File: doc/BRIEF.md
# E3 Frame-Slave Serial Transmit Payload Input

This block is the transmit-side payload entry of an E3 framer when the terminal equipment is the frame master. The framer and the terminal equipment share one 34.368 MHz clock. On each rising edge the block samples one serial data bit and one frame reference bit. The terminal equipment raises the reference for exactly one bit time, on the first bit of a new frame. The block keeps a bit-position counter across the frame and restarts it whenever it sees a rising edge on the reference. It never picks a frame boundary of its own.

Each sampled bit goes out one cycle later with its frame position. Overhead positions raise an overhead indicator and drop the data. Payload positions raise a valid flag toward the frame builder. The reference is synchronous to the clock, so the edge detect is a single register and a compare, with no synchronizer.

If a reference edge arrives anywhere other than the expected frame wrap, the frame restarts there and a sticky slip flag is set. A clear input resets the slip flag. A nibble-mode select input must be held low for serial operation; while it is high, payload bits are not forwarded.

The sequencer has three states. HUNT is entered from reset and waits for the first reference edge. OVERHEAD covers positions 0 to OH_BITS-1. PAYLOAD covers positions OH_BITS to FRAME_BITS-1. The transitions are:
- HUNT to OVERHEAD on a reference rising edge.
- OVERHEAD to PAYLOAD when the next position reaches OH_BITS.
- PAYLOAD to OVERHEAD on the wrap from FRAME_BITS-1 to 0, or on any reference edge.
- OVERHEAD back to OVERHEAD on a reference edge.
- Any state to HUNT on reset.

Top module: `e3s_tx_slave_if`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are cleared: bit_pos is 0, and oh_ind, pay_valid, pay_data and slip_flag are 0. The sequencer returns to HUNT and the stored reference sample is cleared.
- R2: After reset and before the first reference rising edge, pay_valid and oh_ind stay 0 and bit_pos stays 0, whatever value ser_in has.
- R3: A rising edge is a sample where frame_ref is 1 and the previous sample was 0. On such an edge, the outputs after that edge show bit_pos 0 with oh_ind 1. If frame_ref stays high on later samples, the frame does not restart again.
- R4: Once framing has started, bit_pos increases by one on every clock. It wraps from FRAME_BITS-1 to 0 unless a rising edge restarts it.
- R5: While bit_pos is below OH_BITS, oh_ind is 1, pay_valid is 0 and pay_data is 0. The sampled bit is discarded.
- R6: While bit_pos is OH_BITS or more, oh_ind is 0. With nib_sel low, pay_valid is 1 and pay_data equals the ser_in value sampled on the same edge. All outputs have one clock of latency.
- R7: slip_flag is set when a rising edge arrives while framing is running and the current bit_pos is not FRAME_BITS-1. An edge that arrives when bit_pos is FRAME_BITS-1, which is the aligned case, does not set it.
- R8: slip_flag holds until a clock edge where slip_clr is 1 and no new slip occurs. If a slip and slip_clr happen on the same edge, the flag stays set.
- R9: While nib_sel is 1, pay_valid and pay_data are 0 at payload positions. Position counting and the overhead indicator are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 34.368 MHz transmit clock shared with terminal equipment |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial payload bit from terminal equipment |
| frame_ref | input | 1 | One-bit-wide frame start reference, synchronous to clk |
| nib_sel | input | 1 | Nibble-mode select; low for serial operation |
| slip_clr | input | 1 | Clears the sticky slip flag |
| oh_ind | output | 1 | Current position is overhead |
| pay_data | output | 1 | Forwarded payload bit |
| pay_valid | output | 1 | pay_data holds a payload bit |
| bit_pos | output | POS_W | Frame position of the bit on the outputs |
| slip_flag | output | 1 | Sticky flag for a reference edge off the expected wrap |

## Verification
A corrupted position counter shows on bit_pos in the very next cycle. It also makes the overhead and valid windows land on the wrong bits within one frame. A lost or spurious edge-detect sample shows up one cycle after the reference pulse, as a missing or extra restart to position 0 and as a wrong slip_flag. The bench uses a short frame, so every early-edge position and every wrap boundary can be swept. Each cycle's outputs are compared against an arithmetic model of position, window and flag.

// File: rtl/e3s_pkg.sv
package e3s_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_OVERHEAD = 2'd1,
        ST_PAYLOAD  = 2'd2
    } e3s_state_e;

endpackage

// File: rtl/e3s_ref_edge.sv
module e3s_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);

    logic ref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_i;
    end

    assign rise_o = ref_i & ~ref_q;

    // R3: a held-high reference never produces two edges in a row
    assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/e3s_pos_ctr.sv
module e3s_pos_ctr #(
    parameter int FRAME_BITS = 1536,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             run_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic             last_o
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos_q;

    assign last_o = (pos_q == LAST);

    always_comb begin
        if (restart_i)   pos_nxt_o = '0;
        else if (!run_i) pos_nxt_o = pos_q;
        else if (last_o) pos_nxt_o = '0;
        else             pos_nxt_o = pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_nxt_o;
    end

    assign pos_o = pos_q;

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && !last_o) |=> (pos_o == POS_W'($past(pos_o) + 1'b1)));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i && last_o) |=> (pos_o == '0));

    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= LAST);

endmodule

// File: rtl/e3s_slip_flag.sv
module e3s_slip_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/e3s_tx_slave_if.sv
module e3s_tx_slave_if
    import e3s_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             frame_ref,
    input  logic             nib_sel,
    input  logic             slip_clr,
    output logic             oh_ind,
    output logic             pay_data,
    output logic             pay_valid,
    output logic [POS_W-1:0] bit_pos,
    output logic             slip_flag
);

    localparam logic [POS_W-1:0] OH_LIM = POS_W'(OH_BITS);

    e3s_state_e       st_q, st_nxt;
    logic             ref_rise;
    logic             ctr_run;
    logic             ctr_last;
    logic             slip_set;
    logic [POS_W-1:0] pos_nxt;

    e3s_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (frame_ref),
        .rise_o (ref_rise)
    );

    assign ctr_run = (st_q != ST_HUNT);

    e3s_pos_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ref_rise),
        .run_i     (ctr_run),
        .pos_o     (bit_pos),
        .pos_nxt_o (pos_nxt),
        .last_o    (ctr_last)
    );

    // an edge while running that is not on the wrap point is a slip
    assign slip_set = ref_rise && ctr_run && !ctr_last;

    e3s_slip_flag u_slip (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (slip_set),
        .clr_i  (slip_clr),
        .flag_o (slip_flag)
    );

    // next-state decode
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_HUNT:     st_nxt = ref_rise ? ST_OVERHEAD : ST_HUNT;
            ST_OVERHEAD,
            ST_PAYLOAD:  st_nxt = (pos_nxt < OH_LIM) ? ST_OVERHEAD : ST_PAYLOAD;
            default:     st_nxt = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_nxt;
    end

    // registered outputs for the bit sampled on this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oh_ind    <= 1'b0;
            pay_valid <= 1'b0;
            pay_data  <= 1'b0;
        end else begin
            oh_ind    <= (st_nxt == ST_OVERHEAD);
            pay_valid <= (st_nxt == ST_PAYLOAD) && !nib_sel;
            pay_data  <= ((st_nxt == ST_PAYLOAD) && !nib_sel) ? ser_in : 1'b0;
        end
    end

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> (bit_pos == '0 && oh_ind));

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(oh_ind && pay_valid));

    assert_oh_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oh_ind |-> (bit_pos < OH_LIM));

    assert_pay_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (bit_pos >= OH_LIM));

    assert_hunt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && !ref_rise) |=> (!pay_valid && !oh_ind));

    assert_nib_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nib_sel |=> !pay_valid);

endmodule

// File: tb/sim_e3s_tx_slave_if.sv
module sim_e3s_tx_slave_if;

    localparam int F  = 24;
    localparam int OH = 4;
    localparam int PW = $clog2(F);

    logic          clk = 1'b0;
    logic          rst_n, ser_in, frame_ref, nib_sel, slip_clr;
    logic          oh_ind, pay_data, pay_valid, slip_flag;
    logic [PW-1:0] bit_pos;

    int checks = 0;
    int errors = 0;

    // bench model
    bit m_run, m_prev, m_slip;
    int m_pos;

    always #2 clk = ~clk;

    e3s_tx_slave_if #(.FRAME_BITS(F), .OH_BITS(OH)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_ref(frame_ref),
        .nib_sel(nib_sel), .slip_clr(slip_clr), .oh_ind(oh_ind),
        .pay_data(pay_data), .pay_valid(pay_valid), .bit_pos(bit_pos),
        .slip_flag(slip_flag)
    );

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic cyc(input bit rst, input bit s, input bit r, input bit clr, input bit nib);
        bit rise, set, e_oh, e_val, e_dat;
        string tag, stag;
        @(negedge clk);
        rst_n = !rst; ser_in = s; frame_ref = r; slip_clr = clr; nib_sel = nib;
        @(posedge clk);
        rise = r && !m_prev;
        set  = 1'b0;
        if (rst) begin
            m_run = 0; m_pos = 0; m_prev = 0; m_slip = 0;
            tag = "R1"; stag = "R1";
        end else begin
            if (rise) begin
                set = m_run && (m_pos != F - 1);
                m_run = 1; m_pos = 0;
            end else if (m_run) begin
                m_pos = (m_pos == F - 1) ? 0 : m_pos + 1;
            end
            if (set) m_slip = 1;
            else if (clr) m_slip = 0;
            m_prev = r;
            if (!m_run) tag = "R2";
            else if (rise) tag = "R3";
            else if (m_pos < OH) tag = "R5";
            else if (nib) tag = "R9";
            else tag = "R6";
            stag = clr ? "R8" : "R7";
        end
        e_oh  = m_run && (m_pos < OH);
        e_val = m_run && (m_pos >= OH) && !nib;
        e_dat = e_val && s;
        #1;
        chk(tag, "oh_ind", int'(oh_ind), int'(e_oh));
        chk(tag, "pay_valid", int'(pay_valid), int'(e_val));
        chk(tag, "pay_data", int'(pay_data), int'(e_dat));
        chk((tag == "R1" || tag == "R2" || tag == "R3") ? tag : "R4", "bit_pos", int'(bit_pos), m_pos);
        chk(stag, "slip_flag", int'(slip_flag), int'(m_slip));
    endtask

    task automatic run_to(input int p);
        int n = 0;
        while (m_pos != p && n < 4 * F) begin
            cyc(0, n[0] ^ n[2], 0, 0, 0);
            n++;
        end
    endtask

    initial begin
        rst_n = 0; ser_in = 0; frame_ref = 0; nib_sel = 0; slip_clr = 0;
        m_run = 0; m_prev = 0; m_slip = 0; m_pos = 0;
        // R1 reset
        cyc(1, 1, 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
        // R2 hunt: no reference, data toggling
        for (int i = 0; i < 30; i++) cyc(0, i[0] ^ i[2], 0, 0, 0);
        // R3 first edge, then R4/R5/R6 across two full frames with free wrap
        cyc(0, 1, 1, 0, 0);
        for (int i = 0; i < 2 * F + 5; i++) cyc(0, i[1] ^ i[0], 0, 0, 0);
        // R7 aligned edge at wrap: no slip
        run_to(F - 1);
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < F; i++) cyc(0, i[0], 0, 0, 0);
        // R3 held-high reference: one restart only
        run_to(8);
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
        // R8 clear
        cyc(0, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0);
        // R7 sweep of edge positions, including the aligned one
        for (int p = 0; p < F; p++) begin
            run_to(p);
            cyc(0, 1, 1, 0, 0);
            cyc(0, 0, 0, 0, 0);
            cyc(0, 1, 0, 1, 0);
        end
        // R8 slip and clear on the same edge: set wins
        run_to(10);
        cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        // R9 nibble select high across a frame
        for (int i = 0; i < F + 3; i++) cyc(0, ~i[0], 0, 0, 1);
        for (int i = 0; i < F; i++) cyc(0, i[2], 0, 0, 0);
        // R1 mid-frame reset, then R2 hunt again
        run_to(15);
        cyc(1, 1, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        for (int i = 0; i < F; i++) cyc(0, i[0], 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule